// File: doc/BRIEF.md
# NAND Bus Cycle Decoder

This block is the device-side front end of a NAND-style parallel flash interface. It watches the asynchronous bus pins: chip enable, the command and address latch enables, the write and read strobes, write protect and an 8-bit IO bus. It samples them with a fast system clock and sorts every completed write strobe into a command, an address byte or a data-input byte. Everything behind the bus, including the memory array, sees clean single-clock pulses in the system clock domain.

The control strobes (chip enable, write enable, read enable) pass through a two-stage synchronizer and then a run-length glitch filter. A strobe level counts only after it has held for `FILT_SAMPLES` consecutive clock samples. The latch enables, write protect and the IO bus go through a synchronizer of the same depth, so their sampled values line up with the filtered strobes. Classification happens at the filtered rising edge of write enable, using the latch-enable levels seen at that moment. Address bytes are gathered into a fixed five-slot register, with the first byte in the lowest slot. Program-setup (0x80) and erase-setup (0x60) commands are refused whenever the live write-protect level is low. Read-enable falling edges mark data-output cycles. Chip enable high puts the block into standby.

Top module: `nand_bus_decoder`

## Requirements
- R1: Command cycle. If at a filtered write-enable rising edge chip enable is low, CLE is high, ALE is low and read enable is high, `cmdValid` pulses for exactly one clock and `cmdCode` holds IO[7:0]. This does not apply to a refused command (R7).
- R2: Address cycle. If at a write-enable rising edge chip enable is low, ALE is high, CLE is low and read enable is high, the byte goes into slot k of `addr`, that is bits [8k+7:8k], where k is the current `addrCount`. `addrCount` then rises by one.
- R3: A full address is five address cycles. Any further address cycle leaves `addr` unchanged, keeps `addrCount` at 5 and sets `addrOverflow`.
- R4: Every command cycle clears `addrCount` to 0 and `addrOverflow` to 0, whether the command is accepted or refused.
- R5: Data-input cycle. If at a write-enable rising edge chip enable is low, CLE and ALE are both low and read enable is high, `dinValid` pulses for one clock and `dinByte` holds the IO byte. This happens once per strobe.
- R6: An accepted command whose code is 0x80 or 0x60 also pulses `modifyStart` in the same clock as `cmdValid`. Other codes never pulse `modifyStart`.
- R7: A 0x80 or 0x60 command with write protect low at the write-enable rising edge gives `cmdRefused` for one clock and gives neither `cmdValid` nor `modifyStart`. Write protect is taken at its live level and is never latched on the falling strobe. Commands with other codes are still accepted while write protect is low.
- R8: Every read-enable falling edge with chip enable low and write enable high pulses `doutReq` once. `outEnable` is high while chip enable is low, read enable is low and write enable is high.
- R9: With chip enable high, `standby` is 1, `outEnable` is 0 and no write strobe is decoded.
- R10: A low pulse on chip enable, write enable or read enable that lasts fewer than `FILT_SAMPLES` clock samples causes no bus operation and no change to `standby`.
- R11: After reset all pulse outputs are 0, `addrCount` is 0, `addrOverflow` is 0, `addr` is 0 and `standby` is 1.
- R12: A write strobe with CLE and ALE both high is not decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Bus chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| weN | input | 1 | Write strobe, active low |
| reN | input | 1 | Read strobe, active low |
| wpN | input | 1 | Write protect, active low |
| io | input | 8 | Bus IO lines |
| cmdValid | output | 1 | One-clock pulse for an accepted command |
| cmdCode | output | 8 | Code of the last accepted command |
| modifyStart | output | 1 | One-clock pulse for an accepted program or erase setup |
| cmdRefused | output | 1 | One-clock pulse for a modify command blocked by write protect |
| addr | output | 40 | Assembled address, first byte in bits 7:0 |
| addrCount | output | 3 | Address bytes gathered since the last command |
| addrOverflow | output | 1 | Set when an address cycle arrives after five |
| dinValid | output | 1 | One-clock pulse per data-input byte |
| dinByte | output | 8 | Last data-input byte |
| doutReq | output | 1 | One-clock pulse per data-output read strobe |
| outEnable | output | 1 | Output drive indication during a read strobe |
| standby | output | 1 | High while chip enable is high |

## Verification
A wrong address counter shows at the ports on the next address cycle: the byte lands in the wrong slot of `addr`, or `addrCount` and `addrOverflow` disagree. This is visible roughly six clocks after the write strobe rises, and a missed clear on a command is visible just as fast. A bad classification or filter state shows as a pulse with the wrong count or wrong kind after the next strobe. For that reason the bench compares running pulse counts and captured values against its model after every bus cycle, during long random sequences of commands, address bytes, data bytes and write-protect changes.

// File: rtl/nfd_pkg.sv
package nfd_pkg;

  // Control-to-datapath strobes, valid for one clock
  typedef struct packed {
    logic loadCmd;
    logic loadAddr;
    logic loadData;
    logic markModify;
    logic markRefuse;
    logic readReq;
  } nfdStrobe_t;

  localparam logic [7:0] CODE_PROGRAM_SETUP = 8'h80;
  localparam logic [7:0] CODE_ERASE_SETUP   = 8'h60;

  function automatic logic isModifyCode(input logic [7:0] code);
    return (code == CODE_PROGRAM_SETUP) || (code == CODE_ERASE_SETUP);
  endfunction

endpackage

// File: rtl/nfd_sync.sv
module nfd_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= RESET_VAL;
        else       stageQ[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= RESET_VAL;
        else       stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/nfd_glitch_filter.sv
module nfd_glitch_filter #(
  parameter int SAMPLES   = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);

  localparam int CW = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

  logic [CW-1:0] runLen;

  // The output follows only after the new level has been seen SAMPLES times in a row
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cleanOut <= RESET_VAL;
      runLen   <= '0;
    end else if (rawIn == cleanOut) begin
      runLen <= '0;
    end else if (runLen == LAST) begin
      cleanOut <= rawIn;
      runLen   <= '0;
    end else begin
      runLen <= runLen + 1'b1;
    end
  end

endmodule

// File: rtl/nfd_control.sv
module nfd_control
  import nfd_pkg::*;
#(
  parameter int ADDR_CYCLES = 5,
  parameter int CNT_W       = $clog2(ADDR_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceF,
  input  logic             weF,
  input  logic             reF,
  input  logic             cleS,
  input  logic             aleS,
  input  logic             wpS,
  input  logic [7:0]       cmdBits,
  output nfdStrobe_t       strobe,
  output logic [CNT_W-1:0] addrSlot,
  output logic [CNT_W-1:0] addrCount,
  output logic             addrOverflow
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(ADDR_CYCLES);

  logic weQ, reQ;
  logic weRise, reFall, decodeOk;
  logic cmdCyc, addrCyc, dataCyc, modifyCode, refuse, slotFree;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weQ <= 1'b1;
      reQ <= 1'b1;
    end else begin
      weQ <= weF;
      reQ <= reF;
    end
  end

  always_comb begin
    weRise     = weF & ~weQ;
    reFall     = ~reF & reQ;
    decodeOk   = weRise & ~ceF & reF;
    cmdCyc     = decodeOk &  cleS & ~aleS;
    addrCyc    = decodeOk &  aleS & ~cleS;
    dataCyc    = decodeOk & ~cleS & ~aleS;
    modifyCode = isModifyCode(cmdBits);
    refuse     = cmdCyc & modifyCode & ~wpS;
    slotFree   = (addrCount < FULL);

    strobe.loadCmd    = cmdCyc & ~refuse;
    strobe.markModify = cmdCyc & modifyCode & wpS;
    strobe.markRefuse = refuse;
    strobe.loadAddr   = addrCyc & slotFree;
    strobe.loadData   = dataCyc;
    strobe.readReq    = reFall & ~ceF & weF;
    addrSlot          = addrCount;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrCount    <= '0;
      addrOverflow <= 1'b0;
    end else if (cmdCyc) begin
      addrCount    <= '0;
      addrOverflow <= 1'b0;
    end else if (addrCyc) begin
      if (slotFree) addrCount    <= addrCount + 1'b1;
      else          addrOverflow <= 1'b1;
    end
  end

endmodule

// File: rtl/nfd_datapath.sv
module nfd_datapath
  import nfd_pkg::*;
#(
  parameter int ADDR_CYCLES = 5,
  parameter int IO_W        = 8,
  parameter int CNT_W       = $clog2(ADDR_CYCLES + 1),
  parameter int ADDR_W      = ADDR_CYCLES * IO_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  nfdStrobe_t        strobe,
  input  logic [CNT_W-1:0]  addrSlot,
  input  logic [IO_W-1:0]   ioS,
  input  logic              ceF,
  input  logic              weF,
  input  logic              reF,
  output logic              cmdValid,
  output logic [7:0]        cmdCode,
  output logic              modifyStart,
  output logic              cmdRefused,
  output logic [ADDR_W-1:0] addr,
  output logic              dinValid,
  output logic [IO_W-1:0]   dinByte,
  output logic              doutReq,
  output logic              outEnable,
  output logic              standby
);

  logic [IO_W-1:0] slotQ [ADDR_CYCLES];

  for (genvar s = 0; s < ADDR_CYCLES; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        slotQ[s] <= '0;
      else if (strobe.loadAddr && (addrSlot == CNT_W'(s)))
        slotQ[s] <= ioS;
    end
    assign addr[s*IO_W +: IO_W] = slotQ[s];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid    <= 1'b0;
      modifyStart <= 1'b0;
      cmdRefused  <= 1'b0;
      dinValid    <= 1'b0;
      doutReq     <= 1'b0;
      cmdCode     <= '0;
      dinByte     <= '0;
      outEnable   <= 1'b0;
      standby     <= 1'b1;
    end else begin
      cmdValid    <= strobe.loadCmd;
      modifyStart <= strobe.markModify;
      cmdRefused  <= strobe.markRefuse;
      dinValid    <= strobe.loadData;
      doutReq     <= strobe.readReq;
      if (strobe.loadCmd)  cmdCode <= ioS[7:0];
      if (strobe.loadData) dinByte <= ioS;
      outEnable   <= ~ceF & ~reF & weF;
      standby     <= ceF;
    end
  end

endmodule

// File: rtl/nand_bus_decoder.sv
module nand_bus_decoder #(
  parameter int ADDR_CYCLES  = 5,
  parameter int IO_W         = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int FILT_SAMPLES = 2,
  parameter int CNT_W        = $clog2(ADDR_CYCLES + 1),
  parameter int ADDR_W       = ADDR_CYCLES * IO_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              cle,
  input  logic              ale,
  input  logic              weN,
  input  logic              reN,
  input  logic              wpN,
  input  logic [IO_W-1:0]   io,
  output logic              cmdValid,
  output logic [7:0]        cmdCode,
  output logic              modifyStart,
  output logic              cmdRefused,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  addrCount,
  output logic              addrOverflow,
  output logic              dinValid,
  output logic [IO_W-1:0]   dinByte,
  output logic              doutReq,
  output logic              outEnable,
  output logic              standby
);

  import nfd_pkg::*;

  localparam int LVL_W = IO_W + 3;
  localparam int STB_N = 3;

  logic [LVL_W-1:0] lvlS;
  logic [STB_N-1:0] stbS, stbF;
  logic [CNT_W-1:0] addrSlot;
  nfdStrobe_t       strobe;

  // Levels: {cle, ale, wpN, io}; strobes: {ceN, weN, reN}
  nfd_sync #(.WIDTH(LVL_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)) i_lvlSync (
    .clk(clk), .rstN(rstN), .asyncIn({cle, ale, wpN, io}), .syncOut(lvlS)
  );

  nfd_sync #(.WIDTH(STB_N), .STAGES(SYNC_STAGES), .RESET_VAL('1)) i_stbSync (
    .clk(clk), .rstN(rstN), .asyncIn({ceN, weN, reN}), .syncOut(stbS)
  );

  for (genvar p = 0; p < STB_N; p++) begin : g_filt
    nfd_glitch_filter #(.SAMPLES(FILT_SAMPLES), .RESET_VAL(1'b1)) i_filt (
      .clk(clk), .rstN(rstN), .rawIn(stbS[p]), .cleanOut(stbF[p])
    );
  end

  nfd_control #(.ADDR_CYCLES(ADDR_CYCLES), .CNT_W(CNT_W)) i_control (
    .clk(clk), .rstN(rstN),
    .ceF(stbF[2]), .weF(stbF[1]), .reF(stbF[0]),
    .cleS(lvlS[IO_W+2]), .aleS(lvlS[IO_W+1]), .wpS(lvlS[IO_W]),
    .cmdBits(lvlS[7:0]),
    .strobe(strobe), .addrSlot(addrSlot),
    .addrCount(addrCount), .addrOverflow(addrOverflow)
  );

  nfd_datapath #(.ADDR_CYCLES(ADDR_CYCLES), .IO_W(IO_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addrSlot(addrSlot),
    .ioS(lvlS[IO_W-1:0]),
    .ceF(stbF[2]), .weF(stbF[1]), .reF(stbF[0]),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .modifyStart(modifyStart),
    .cmdRefused(cmdRefused), .addr(addr), .dinValid(dinValid),
    .dinByte(dinByte), .doutReq(doutReq), .outEnable(outEnable),
    .standby(standby)
  );

endmodule

// File: rtl/nand_bus_decoder_chk.sv
module nand_bus_decoder_chk #(
  parameter int ADDR_CYCLES = 5,
  parameter int CNT_W       = $clog2(ADDR_CYCLES + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [7:0]       cmdCode,
  input logic             modifyStart,
  input logic             cmdRefused,
  input logic [CNT_W-1:0] addrCount,
  input logic             addrOverflow,
  input logic             dinValid,
  input logic             standby
);

  // R4
  cmd_clears_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid || cmdRefused) |-> (addrCount == '0 && !addrOverflow));

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrCount <= CNT_W'(ADDR_CYCLES));

  // R3
  overflow_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrOverflow) |-> (addrCount == CNT_W'(ADDR_CYCLES)));

  // R6
  modify_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    modifyStart |-> (cmdValid && (cmdCode == 8'h80 || cmdCode == 8'h60)));

  // R7
  refuse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdRefused |-> (!cmdValid && !modifyStart));

  // R9
  no_din_in_standby_chk: assert property (@(posedge clk) disable iff (!rstN)
    dinValid |-> !standby);

  // R1
  cmd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

endmodule

bind nand_bus_decoder nand_bus_decoder_chk #(.ADDR_CYCLES(ADDR_CYCLES), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
  .modifyStart(modifyStart), .cmdRefused(cmdRefused), .addrCount(addrCount),
  .addrOverflow(addrOverflow), .dinValid(dinValid), .standby(standby)
);

// File: tb/test_nand_bus_decoder.sv
`timescale 1ns/1ps
module test_nand_bus_decoder;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, cle = 1'b0, ale = 1'b0, weN = 1'b1, reN = 1'b1, wpN = 1'b1;
  logic [7:0] io = '0;
  logic cmdValid, modifyStart, cmdRefused, addrOverflow, dinValid, doutReq, outEnable, standby;
  logic [7:0] cmdCode, dinByte;
  logic [39:0] addr;
  logic [2:0] addrCount;

  always #4 clk = ~clk;

  nand_bus_decoder i_nand_bus_decoder (
    .clk(clk), .rstN(rstN), .ceN(ceN), .cle(cle), .ale(ale), .weN(weN),
    .reN(reN), .wpN(wpN), .io(io), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .modifyStart(modifyStart), .cmdRefused(cmdRefused), .addr(addr),
    .addrCount(addrCount), .addrOverflow(addrOverflow), .dinValid(dinValid),
    .dinByte(dinByte), .doutReq(doutReq), .outEnable(outEnable), .standby(standby)
  );

  int checks = 0, fails = 0;
  int nCmd = 0, nMod = 0, nRef = 0, nDin = 0, nDout = 0, nStbyDrop = 0;
  int wideCmd = 0;
  logic stbyPrev = 1'b1;

  // Pulse monitor away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (cmdValid) nCmd++;
      if (modifyStart) nMod++;
      if (cmdRefused) nRef++;
      if (dinValid) nDin++;
      if (doutReq) nDout++;
      if (stbyPrev && !standby) nStbyDrop++;
      stbyPrev = standby;
    end
  end

  // Expected model
  int eCmd = 0, eMod = 0, eRef = 0, eDin = 0, eDout = 0;
  logic [39:0] eAddr = '0;
  int eCnt = 0;
  logic eOvf = 1'b0;
  logic [7:0] eCode = '0, eDinByte = '0;

  function automatic logic modCode(input logic [7:0] c);
    return (c == 8'h80) || (c == 8'h60);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeCycle(input logic c, input logic a, input logic [7:0] d, input logic wpAtRise);
    @(negedge clk);
    cle = c; ale = a; io = d;
    repeat (2) @(negedge clk);
    weN = 1'b0;
    @(negedge clk);
    wpN = wpAtRise;
    repeat (3) @(negedge clk);
    weN = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic doCmd(input logic [7:0] code, input logic wp);
    wpN = 1'b1;
    writeCycle(1'b1, 1'b0, code, wp);
    eCnt = 0; eOvf = 1'b0;
    if (modCode(code) && !wp) eRef++;
    else begin
      eCmd++; eCode = code;
      if (modCode(code)) eMod++;
    end
  endtask

  task automatic doAddr(input logic [7:0] b);
    writeCycle(1'b0, 1'b1, b, wpN);
    if (eCnt < 5) begin eAddr[eCnt*8 +: 8] = b; eCnt++; end
    else eOvf = 1'b1;
  endtask

  task automatic doData(input logic [7:0] b);
    writeCycle(1'b0, 1'b0, b, wpN);
    eDin++; eDinByte = b;
  endtask

  task automatic compareAll(input string tag);
    chk({tag, " R1 cmd count"}, nCmd, eCmd);
    chk({tag, " R1 cmd code"}, cmdCode, eCode);
    chk({tag, " R6 modify count"}, nMod, eMod);
    chk({tag, " R7 refused count"}, nRef, eRef);
    chk({tag, " R2 addr"}, addr, eAddr);
    chk({tag, " R3 addr count"}, addrCount, eCnt);
    chk({tag, " R4 overflow"}, addrOverflow, eOvf);
    chk({tag, " R5 din count"}, nDin, eDin);
    chk({tag, " R5 din byte"}, dinByte, eDinByte);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 standby", standby, 1'b1);
    chk("R11 addrCount", addrCount, 0);
    chk("R11 overflow", addrOverflow, 1'b0);
    chk("R11 pulses", {cmdValid, modifyStart, cmdRefused, dinValid, doutReq}, 5'b0);
    chk("R11 addr", addr, 40'h0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R9 strobe while in standby is not decoded
    writeCycle(1'b1, 1'b0, 8'h70, 1'b1);
    chk("R9 no cmd in standby", nCmd, 0);
    chk("R9 standby high", standby, 1'b1);
    chk("R9 outEnable low", outEnable, 1'b0);

    // R10 chip enable glitch
    @(negedge clk); #2 ceN = 1'b0; #3 ceN = 1'b1;
    repeat (8) @(negedge clk);
    chk("R10 ce glitch no standby drop", nStbyDrop, 0);

    ceN = 1'b0;
    repeat (8) @(negedge clk);
    chk("R9 standby low when selected", standby, 1'b0);

    // R1 / R6 directed
    doCmd(8'h00, 1'b1); compareAll("dir read");
    doCmd(8'h80, 1'b1); compareAll("dir program");
    // R2 / R3 five address bytes then overflow
    doAddr(8'h11); doAddr(8'h22); doAddr(8'h33); doAddr(8'h44); doAddr(8'h55);
    compareAll("dir five");
    chk("R2 full address", addr, 40'h55_44_33_22_11);
    doAddr(8'h99);
    compareAll("dir overflow");
    chk("R3 overflow set", addrOverflow, 1'b1);
    // R4 command clears
    doCmd(8'h60, 1'b1); compareAll("dir erase");
    chk("R4 cleared count", addrCount, 0);
    // R7 refused, wp dropped only while strobe low (not latched at fall)
    doCmd(8'h80, 1'b0); compareAll("dir wp refuse");
    doCmd(8'h70, 1'b0); compareAll("dir wp status ok");
    // R12 both latch enables high
    writeCycle(1'b1, 1'b1, 8'hA5, 1'b1);
    compareAll("R12 both high");
    // R5 data
    doData(8'h3C); doData(8'hC3); compareAll("dir data");

    // R10 write enable glitch with command set up
    @(negedge clk); cle = 1'b1; io = 8'hFF;
    repeat (3) @(negedge clk);
    #2 weN = 1'b0; #3 weN = 1'b1;
    repeat (8) @(negedge clk);
    cle = 1'b0;
    compareAll("R10 we glitch");

    // R8 read strobes
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); reN = 1'b0;
      repeat (6) @(negedge clk);
      chk("R8 outEnable during read", outEnable, 1'b1);
      reN = 1'b1; eDout++;
      repeat (6) @(negedge clk);
      chk("R8 outEnable after read", outEnable, 1'b0);
    end
    chk("R8 dout count", nDout, eDout);
    // R10 read enable glitch
    @(negedge clk); #2 reN = 1'b0; #3 reN = 1'b1;
    repeat (8) @(negedge clk);
    chk("R10 re glitch", nDout, eDout);

    // Random mix
    for (int n = 0; n < 300; n++) begin
      int pick;
      logic [7:0] b;
      pick = $urandom_range(0, 9);
      b = 8'($urandom);
      if (pick < 2) begin
        if ($urandom_range(0, 1) == 1) b = ($urandom_range(0, 1) == 1) ? 8'h80 : 8'h60;
        doCmd(b, 1'($urandom_range(0, 1)));
      end else if (pick < 7) doAddr(b);
      else doData(b);
      compareAll("random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule